// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Unit

This block sits between a set of interrupt sources and the control logic of a processor whose status word carries a 3-bit running interrupt level. At each instruction boundary it compares the encoded level of the pending request with that running level. When the request wins, the block saves the return address and the whole status word on a small internal stack. It then raises the running level to the accepted one, switches to supervisor privilege, and runs an acknowledge handshake with the device.

During the handshake the block drives an acknowledge strobe and puts the acknowledged level on an address bus. It waits for the device to report that its vector is ready. The handler entry address is the table base plus that vector. If the device never answers, a timeout ends the handshake with a bus-error pulse. A return-from-exception request pops the newest stack entry and restores the saved status word and return address. Software may rewrite the status word, for example to lower the running level inside a handler so that lower-level requests can nest.

Top module: `iau_accept_unit`

## Requirements
- R1: After reset the status word equals 16'h0000, and the acknowledge strobe, handler-valid, restore-valid, bus-error and overflow outputs are all low.
- R2: A request (level 1..7 on `irq_level_i`, level 0 meaning none) is taken only in a cycle where `insn_boundary_i` is high, no handshake is running, and the request level is strictly greater than the running level held in status bits [10:8].
- R3: A level-7 request is taken even when the running level is already 7.
- R4: In the cycle after acceptance, status bits [10:8] hold the accepted level, status bit 13 (supervisor) is 1, `iack_o` is high, and `iack_addr_o` carries the accepted level, held stable until the handshake ends.
- R5: When `dev_ready_i` is high during the handshake, in the next cycle `iack_o` is low, `handler_valid_o` pulses for one cycle, and `handler_pc_o` equals `vec_base_i` plus the zero-extended `dev_vector_i`.
- R6: If `dev_ready_i` stays low, `iack_o` stays high for exactly 16 cycles, then drops, and `bus_err_o` pulses in the same cycle that it drops. The raised level is kept.
- R7: `rte_i` with a non-empty stack pops the newest entry. In the next cycle `restore_valid_o` pulses, `restore_pc_o` shows the saved return address, and the status word is the one saved at that acceptance, so nested levels unwind newest first.
- R8: `rte_i` with an empty stack has no effect: no restore pulse, and the status word is unchanged.
- R9: A software write (`sr_wr_i`) replaces the status word in the next cycle. Lowering the level this way lets a request above the new level, but below the old one, be taken.
- R10: When the 8-entry stack is full, a request that would otherwise be taken is refused. `ovf_err_o` pulses in the next cycle, no handshake starts, and the status word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_level_i | input | 3 | Encoded pending request level, 0 = none |
| insn_boundary_i | input | 1 | High in the cycle an instruction completes |
| pc_i | input | 16 | Return address to save on acceptance |
| rte_i | input | 1 | Return-from-exception request |
| sr_wr_i | input | 1 | Software write of the status word |
| sr_wdata_i | input | 16 | Status word value to write |
| vec_base_i | input | 16 | Base address of the handler table |
| dev_ready_i | input | 1 | Device has placed its vector |
| dev_vector_i | input | 8 | Vector supplied by the device |
| sr_o | output | 16 | Current status word |
| iack_o | output | 1 | Acknowledge strobe |
| iack_addr_o | output | 3 | Level being acknowledged |
| handler_valid_o | output | 1 | One-cycle pulse: handler address is valid |
| handler_pc_o | output | 16 | Handler entry address |
| bus_err_o | output | 1 | One-cycle pulse: acknowledge timed out |
| restore_valid_o | output | 1 | One-cycle pulse: return address restored |
| restore_pc_o | output | 16 | Restored return address |
| ovf_err_o | output | 1 | One-cycle pulse: request refused, stack full |

## Verification
The acceptance comparison is exercised with requests equal to, below and above the running level, and with a winning level offered while the boundary strobe is low. These cases separate a strict comparison from a non-strict one and show that the boundary gate is honoured. Level 7 is offered at running level 7 to show the non-maskable exception to the strict rule. Software lowers the level between two nested requests to show that the level register can be rewritten. Two-deep and eight-deep nesting followed by returns checks that unwinding runs newest first and that both the return address and the level come back. A silent device checks the exact timeout length, and a ninth level-7 request checks that a full stack refuses it.

// File: rtl/iau_pkg.sv
package iau_pkg;

   typedef enum logic [0:0] {
      ACK_IDLE = 1'b0,
      ACK_WAIT = 1'b1
   } ack_state_e;

endpackage

// File: rtl/iau_level_cmp.sv
module iau_level_cmp #(
   parameter int LVL_W  = 3,
   parameter bit NMI_EN = 1'b1
) (
   input  logic [LVL_W-1:0] req_lvl_i,
   input  logic [LVL_W-1:0] cur_lvl_i,
   output logic             wins_o
);

   localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

   logic above;
   assign above = (req_lvl_i > cur_lvl_i);

   generate
      if (LVL_W < 1) begin : g_bad_width
         $error("iau_level_cmp: LVL_W must be at least 1");
      end
      if (NMI_EN) begin : g_nmi
         assign wins_o = above || (req_lvl_i == TOP_LVL);
      end else begin : g_plain
         assign wins_o = above;
      end
   endgenerate

endmodule

// File: rtl/iau_save_stack.sv
module iau_save_stack #(
   parameter int DEPTH = 8,
   parameter int EW    = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [EW-1:0] push_data_i,
   output logic [EW-1:0] top_data_o,
   output logic          full_o,
   output logic          empty_o
);

   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("iau_save_stack: DEPTH must be at least 1");
      end
   endgenerate

   logic [EW-1:0] mem [DEPTH];
   logic [PW-1:0] cnt_q;

   assign full_o     = (cnt_q == PW'(DEPTH));
   assign empty_o    = (cnt_q == '0);
   assign top_data_o = mem[IW'(cnt_q - 1'b1)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (push_i && !full_o) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (pop_i && !empty_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_i && !full_o) begin
         mem[IW'(cnt_q)] <= push_data_i;
      end
   end

   // R10
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && full_o));

   // R8
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop_i && empty_o));

endmodule

// File: rtl/iau_ack_seq.sv
module iau_ack_seq
   import iau_pkg::*;
#(
   parameter int LVL_W   = 3,
   parameter int AW      = 16,
   parameter int VW      = 8,
   parameter int ACK_TMO = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             dev_ready_i,
   input  logic [VW-1:0]    dev_vector_i,
   input  logic [AW-1:0]    vec_base_i,
   output logic             busy_o,
   output logic             iack_o,
   output logic [LVL_W-1:0] iack_addr_o,
   output logic             done_o,
   output logic [AW-1:0]    handler_pc_o,
   output logic             bus_err_o
);

   localparam int TW = $clog2(ACK_TMO + 1);

   generate
      if (ACK_TMO < 2) begin : g_bad_tmo
         $error("iau_ack_seq: ACK_TMO must be at least 2");
      end
      if (VW > AW) begin : g_bad_vw
         $error("iau_ack_seq: vector wider than address");
      end
   endgenerate

   ack_state_e       st_q;
   logic [TW-1:0]    tmr_q;
   logic [LVL_W-1:0] lvl_q;

   assign busy_o      = (st_q == ACK_WAIT);
   assign iack_o      = busy_o;
   assign iack_addr_o = lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ACK_IDLE;
         tmr_q        <= '0;
         lvl_q        <= '0;
         done_o       <= 1'b0;
         bus_err_o    <= 1'b0;
         handler_pc_o <= '0;
      end else begin
         done_o    <= 1'b0;
         bus_err_o <= 1'b0;
         unique case (st_q)
            ACK_IDLE: begin
               if (start_i) begin
                  st_q  <= ACK_WAIT;
                  lvl_q <= lvl_i;
                  tmr_q <= '0;
               end
            end
            ACK_WAIT: begin
               if (dev_ready_i) begin
                  st_q         <= ACK_IDLE;
                  done_o       <= 1'b1;
                  handler_pc_o <= vec_base_i + AW'(dev_vector_i);
               end else if (tmr_q == TW'(ACK_TMO - 1)) begin
                  st_q      <= ACK_IDLE;
                  bus_err_o <= 1'b1;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            default: st_q <= ACK_IDLE;
         endcase
      end
   end

   // R4
   ack_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_o && $past(iack_o)) |-> $stable(iack_addr_o));

   // R5
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(iack_o) && !iack_o));

   // R6
   err_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err_o |-> ($past(iack_o) && !$past(dev_ready_i) && !done_o));

endmodule

// File: rtl/iau_accept_unit.sv
module iau_accept_unit #(
   parameter int           LVL_W   = 3,
   parameter int           SW_W    = 16,
   parameter int           LVL_LSB = 8,
   parameter int           SUP_BIT = 13,
   parameter int           AW      = 16,
   parameter int           VW      = 8,
   parameter int           DEPTH   = 8,
   parameter int           ACK_TMO = 16,
   parameter bit           NMI_EN  = 1'b1,
   parameter logic [15:0]  RST_SR  = 16'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] irq_level_i,
   input  logic             insn_boundary_i,
   input  logic [AW-1:0]    pc_i,
   input  logic             rte_i,
   input  logic             sr_wr_i,
   input  logic [SW_W-1:0]  sr_wdata_i,
   input  logic [AW-1:0]    vec_base_i,
   input  logic             dev_ready_i,
   input  logic [VW-1:0]    dev_vector_i,
   output logic [SW_W-1:0]  sr_o,
   output logic             iack_o,
   output logic [LVL_W-1:0] iack_addr_o,
   output logic             handler_valid_o,
   output logic [AW-1:0]    handler_pc_o,
   output logic             bus_err_o,
   output logic             restore_valid_o,
   output logic [AW-1:0]    restore_pc_o,
   output logic             ovf_err_o
);

   localparam int EW = AW + SW_W;

   generate
      if (LVL_LSB + LVL_W > SW_W) begin : g_bad_lvl
         $error("iau_accept_unit: level field outside status word");
      end
      if (SUP_BIT >= SW_W) begin : g_bad_sup
         $error("iau_accept_unit: supervisor bit outside status word");
      end
      if ((SUP_BIT >= LVL_LSB) && (SUP_BIT < LVL_LSB + LVL_W)) begin : g_overlap
         $error("iau_accept_unit: supervisor bit overlaps level field");
      end
   endgenerate

   logic [SW_W-1:0]  sr_q;
   logic [LVL_W-1:0] cur_lvl;
   logic             wins;
   logic             busy;
   logic             can_take;
   logic             accept;
   logic             rte_go;
   logic             stk_full;
   logic             stk_empty;
   logic [EW-1:0]    stk_top;
   logic [EW-1:0]    stk_push_data;
   logic [SW_W-1:0]  sr_taken;

   assign cur_lvl = sr_q[LVL_LSB +: LVL_W];
   assign sr_o    = sr_q;

   iau_level_cmp #(
      .LVL_W  (LVL_W),
      .NMI_EN (NMI_EN)
   ) u_cmp (
      .req_lvl_i (irq_level_i),
      .cur_lvl_i (cur_lvl),
      .wins_o    (wins)
   );

   assign can_take      = insn_boundary_i && !busy && !rte_i && wins;
   assign accept        = can_take && !stk_full;
   assign rte_go        = rte_i && !busy && !stk_empty;
   assign stk_push_data = {pc_i, sr_q};

   always_comb begin
      sr_taken                        = sr_q;
      sr_taken[LVL_LSB +: LVL_W]      = irq_level_i;
      sr_taken[SUP_BIT]               = 1'b1;
   end

   iau_save_stack #(
      .DEPTH (DEPTH),
      .EW    (EW)
   ) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (accept),
      .pop_i       (rte_go),
      .push_data_i (stk_push_data),
      .top_data_o  (stk_top),
      .full_o      (stk_full),
      .empty_o     (stk_empty)
   );

   iau_ack_seq #(
      .LVL_W   (LVL_W),
      .AW      (AW),
      .VW      (VW),
      .ACK_TMO (ACK_TMO)
   ) u_ack (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (accept),
      .lvl_i        (irq_level_i),
      .dev_ready_i  (dev_ready_i),
      .dev_vector_i (dev_vector_i),
      .vec_base_i   (vec_base_i),
      .busy_o       (busy),
      .iack_o       (iack_o),
      .iack_addr_o  (iack_addr_o),
      .done_o       (handler_valid_o),
      .handler_pc_o (handler_pc_o),
      .bus_err_o    (bus_err_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q            <= SW_W'(RST_SR);
         restore_valid_o <= 1'b0;
         restore_pc_o    <= '0;
         ovf_err_o       <= 1'b0;
      end else begin
         restore_valid_o <= rte_go;
         ovf_err_o       <= can_take && stk_full;
         if (rte_go) begin
            restore_pc_o <= stk_top[EW-1 -: AW];
         end
         if (accept) begin
            sr_q <= sr_taken;
         end else if (rte_go) begin
            sr_q <= stk_top[SW_W-1:0];
         end else if (sr_wr_i) begin
            sr_q <= sr_wdata_i;
         end
      end
   end

   // R2
   take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iack_o) |-> $past(insn_boundary_i));

   // R4
   level_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iack_o) |-> (sr_q[LVL_LSB +: LVL_W] == iack_addr_o && sr_q[SUP_BIT]));

   // R10
   ovf_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err_o |-> ($stable(sr_q) && !$rose(iack_o)));

   // R7
   restore_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid_o |-> !$rose(iack_o));

endmodule

// File: tb/iau_accept_unit_test.sv
module iau_accept_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  irq_level = '0;
   logic        boundary = 1'b0;
   logic [15:0] pc = '0;
   logic        rte = 1'b0;
   logic        sr_wr = 1'b0;
   logic [15:0] sr_wdata = '0;
   logic [15:0] vec_base = 16'h4000;
   logic        dev_ready = 1'b0;
   logic [7:0]  dev_vec = '0;
   logic [15:0] sr;
   logic        iack;
   logic [2:0]  iack_addr;
   logic        hvalid;
   logic [15:0] hpc;
   logic        bus_err;
   logic        rvalid;
   logic [15:0] rpc;
   logic        ovf;

   int n_checks = 0;
   int n_fail   = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   iau_accept_unit uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .irq_level_i     (irq_level),
      .insn_boundary_i (boundary),
      .pc_i            (pc),
      .rte_i           (rte),
      .sr_wr_i         (sr_wr),
      .sr_wdata_i      (sr_wdata),
      .vec_base_i      (vec_base),
      .dev_ready_i     (dev_ready),
      .dev_vector_i    (dev_vec),
      .sr_o            (sr),
      .iack_o          (iack),
      .iack_addr_o     (iack_addr),
      .handler_valid_o (hvalid),
      .handler_pc_o    (hpc),
      .bus_err_o       (bus_err),
      .restore_valid_o (rvalid),
      .restore_pc_o    (rpc),
      .ovf_err_o       (ovf)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic take(input logic [2:0] lvl, input logic [15:0] pcv);
      irq_level = lvl; boundary = 1'b1; pc = pcv;
      step();
      irq_level = '0; boundary = 1'b0;
   endtask

   task automatic supply(input logic [7:0] v);
      dev_ready = 1'b1; dev_vec = v;
      step();
      dev_ready = 1'b0;
      chk(hvalid == 1'b1, "R5 handler valid", 32'(hvalid), 1);
      chk(hpc == vec_base + 16'(v), "R5 handler pc", 32'(hpc), 32'(vec_base + 16'(v)));
      chk(iack == 1'b0, "R5 iack released", 32'(iack), 0);
   endtask

   task automatic do_rte();
      rte = 1'b1;
      step();
      rte = 1'b0;
   endtask

   task automatic write_sr(input logic [15:0] v);
      sr_wr = 1'b1; sr_wdata = v;
      step();
      sr_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk(sr == 16'h0000, "R1 sr reset", 32'(sr), 0);
      chk({iack, hvalid, rvalid, bus_err, ovf} == 5'b0, "R1 outputs idle",
          32'({iack, hvalid, rvalid, bus_err, ovf}), 0);
   endtask

   task automatic t_accept_and_nest();
      take(3'd3, 16'h1000);
      chk(iack == 1'b1, "R4 iack on accept", 32'(iack), 1);
      chk(iack_addr == 3'd3, "R4 level on addr", 32'(iack_addr), 3);
      chk(sr == 16'h2300, "R4 sr raised + supervisor", 32'(sr), 32'h2300);
      step();
      chk(iack_addr == 3'd3, "R4 addr held", 32'(iack_addr), 3);
      supply(8'h20);
      step();
      chk(hvalid == 1'b0, "R5 valid one cycle", 32'(hvalid), 0);
      take(3'd3, 16'h1004);
      chk(iack == 1'b0 && sr == 16'h2300, "R2 equal level refused", 32'(sr), 32'h2300);
      take(3'd2, 16'h1008);
      chk(iack == 1'b0, "R2 lower level refused", 32'(iack), 0);
      irq_level = 3'd5; boundary = 1'b0;
      step();
      irq_level = '0;
      chk(iack == 1'b0 && sr == 16'h2300, "R2 no boundary refused", 32'(sr), 32'h2300);
      take(3'd5, 16'h1100);
      chk(iack == 1'b1 && sr == 16'h2500, "R2 higher level taken", 32'(sr), 32'h2500);
      supply(8'h34);
   endtask

   task automatic t_unwind();
      do_rte();
      chk(rvalid == 1'b1 && rpc == 16'h1100, "R7 first pop pc", 32'(rpc), 32'h1100);
      chk(sr == 16'h2300, "R7 first pop sr", 32'(sr), 32'h2300);
      do_rte();
      chk(rvalid == 1'b1 && rpc == 16'h1000, "R7 second pop pc", 32'(rpc), 32'h1000);
      chk(sr == 16'h0000, "R7 second pop sr", 32'(sr), 0);
      do_rte();
      chk(rvalid == 1'b0, "R8 empty rte no restore", 32'(rvalid), 0);
      chk(sr == 16'h0000, "R8 empty rte sr kept", 32'(sr), 0);
   endtask

   task automatic t_nmi();
      write_sr(16'h0700);
      chk(sr == 16'h0700, "R9 sr write", 32'(sr), 32'h0700);
      take(3'd7, 16'h1200);
      chk(iack == 1'b1 && iack_addr == 3'd7, "R3 level7 at level7", 32'(iack), 1);
      supply(8'h02);
      do_rte();
      chk(sr == 16'h0700 && rpc == 16'h1200, "R7 nmi restore", 32'(sr), 32'h0700);
      write_sr(16'h0000);
   endtask

   task automatic t_sw_lower();
      take(3'd6, 16'h2000);
      supply(8'h10);
      take(3'd4, 16'h2004);
      chk(iack == 1'b0 && sr == 16'h2600, "R2 below level 6 refused", 32'(sr), 32'h2600);
      write_sr(16'h2200);
      take(3'd4, 16'h2100);
      chk(iack == 1'b1 && sr == 16'h2400, "R9 nest after lowering", 32'(sr), 32'h2400);
      supply(8'h11);
      do_rte();
      chk(sr == 16'h2200 && rpc == 16'h2100, "R9 lowered sr restored", 32'(sr), 32'h2200);
      do_rte();
      chk(sr == 16'h0000 && rpc == 16'h2000, "R7 outer restored", 32'(sr), 0);
   endtask

   task automatic t_timeout();
      int n = 0;
      take(3'd2, 16'h3000);
      while (iack && n < 100) begin
         n++;
         step();
      end
      chk(n == 16, "R6 iack length", 32'(n), 16);
      chk(bus_err == 1'b1, "R6 bus error pulse", 32'(bus_err), 1);
      chk(sr == 16'h2200, "R6 level kept", 32'(sr), 32'h2200);
      step();
      chk(bus_err == 1'b0, "R6 pulse one cycle", 32'(bus_err), 0);
      do_rte();
   endtask

   task automatic t_overflow();
      for (int i = 0; i < 8; i++) begin
         take(3'd7, 16'h5000 + 16'(i));
         supply(8'(i));
      end
      take(3'd7, 16'h5100);
      chk(ovf == 1'b1, "R10 overflow pulse", 32'(ovf), 1);
      chk(iack == 1'b0, "R10 no ack when full", 32'(iack), 0);
      chk(sr == 16'h2700, "R10 sr unchanged", 32'(sr), 32'h2700);
      for (int i = 0; i < 8; i++) begin
         do_rte();
      end
      chk(sr == 16'h0000 && rpc == 16'h5000, "R7 deep unwind", 32'(rpc), 32'h5000);
   endtask

   initial begin
      #(20 * 100000);
      if (!done_flag) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_accept_and_nest();
      t_unwind();
      t_nmi();
      t_sw_lower();
      t_timeout();
      t_overflow();
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule